// File: doc/BRIEF.md
# Micro-step instruction sequencer

This controller accepts an 8-bit instruction word and expands it into a fixed procedure of up to four micro-steps. Each micro-step puts a 7-bit control word on the control bus: a 5-bit enumerator that selects a register or an ALU function, followed by two parameter bits. A step is held for a parameterised number of ticks, at least four. During the step the step line stays high. The bus clock stays low for the first two ticks and goes high from the third tick, so the enumeration decoders have settled before any register acts.

The sequencer decodes four kinds of instruction: register moves, increments of AX or BX, shifts, and jumps. A shift step does not end until the ALU has signalled completion. An instruction that issues no steps (NOP, a jump or an unknown opcode) completes in the cycle it is accepted. The block also owns the program counter. When an instruction completes, the counter advances by one. The exception is a jump whose flag condition holds, which loads the counter from the index-pointer input instead.

Top module: `microstep_sequencer`

## Requirements
- R1: Asynchronous reset sets pc_o to 0, fetch_o to 1, and step_o, bus_clk_o and ctrl_o to 0.
- R2: An opcode 00 sss ddd other than 0x00 issues two steps. The first step is ctrl {00,sss,01} (source select). The second step is ctrl {00,ddd,10} (destination write). Control word bit order is {enum[4:0], param1, param0}.
- R3: Opcode 0x00 and every undecoded opcode issue no step. pc_o advances by one at the accept edge, and fetch_o stays high.
- R4: Opcode 0101010x issues four steps in this order: {00001,01}, then {0001,~x,01}, then {01010,10}, then {0001,x,10}.
- R5: While steps are being issued, step_o is high continuously. Each step lasts STEP_TICKS cycles, apart from a shift step extended under R6. Within a step, bus_clk_o is low on ticks one and two and high from tick three to the end of the step. When no step is active, ctrl_o is 0 and bus_clk_o is 0.
- R6: Opcode 011010rd issues a shift step {01101,r,d} followed by {00010,10}. The shift step does not end until alu_irq_i has been high on some cycle of that step. If the pulse arrives early it is remembered; if it has not arrived, the step is held at its last tick.
- R7: pc_o increments by one on the edge that ends the last step of a non-jump instruction.
- R8: Opcode 11000ccc is a jump. It takes its condition from flags_i, where bit 0 is zero, bit 1 is equal, bit 2 is greater and bit 3 is carry. The conditions by ccc are: 0 zero; 1 zero or equal; 2 equal; 3 not equal; 4 equal or greater; 5 greater; 6 carry; 7 always.
- R9: A jump whose condition holds loads pc_o from ip_i at the accept edge. A jump whose condition fails increments pc_o by one.
- R10: fetch_o is high exactly when no step is active. Instructions are taken only when fetch_o is high, so instr_valid_i, flags_i and ip_i have no effect while steps run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Tick clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_i | input | 8 | Fetched instruction |
| instr_valid_i | input | 1 | instr_i holds a new instruction |
| flags_i | input | 4 | {carry, greater, equal, zero} |
| ip_i | input | PC_W | Index pointer, the jump target |
| alu_irq_i | input | 1 | ALU completion pulse for shift steps |
| fetch_o | output | 1 | Ready to accept an instruction |
| step_o | output | 1 | Step line, high while a micro-step is active |
| ctrl_o | output | 7 | Control word {enum, param1, param0} |
| bus_clk_o | output | 1 | Bus clock, high from tick three of each step |
| pc_o | output | PC_W | Program counter |

## Verification
The hardest case to reach is a shift step whose ALU pulse arrives at an awkward time. The pulse may come during the early ticks, before the step could end, or it may come long after the last tick, so the step must stall. The bench issues the shift opcode several times with the pulse delayed by different numbers of cycles after acceptance, covering both cases. A behavioural model checks every cycle that the step is neither cut short nor held too long. A separate hazard is a new instruction presented while steps are running. The bench pulses instr_valid_i with a conflicting opcode in the middle of a move and checks that the step sequence and the counter are undisturbed.

// File: rtl/useq_pkg.sv
package useq_pkg;
  localparam int INSTR_W   = 8;
  localparam int ENUM_W    = 5;
  localparam int PARM_W    = 2;
  localparam int CTRL_W    = ENUM_W + PARM_W;
  localparam int FLAG_W    = 4;
  localparam int MAX_STEPS = 4;
  localparam int IDX_W     = $clog2(MAX_STEPS);
  localparam int CNT_W     = $clog2(MAX_STEPS + 1);

  localparam int F_ZERO  = 0;
  localparam int F_EQUAL = 1;
  localparam int F_GREAT = 2;
  localparam int F_CARRY = 3;

  localparam logic [ENUM_W-1:0] E_FLAGS = 5'b00001;
  localparam logic [ENUM_W-1:0] E_AX    = 5'b00010;
  localparam logic [ENUM_W-1:0] E_ADD   = 5'b01010;
  localparam logic [ENUM_W-1:0] E_SHIFT = 5'b01101;

  localparam logic [PARM_W-1:0] P_SRC = 2'b01;
  localparam logic [PARM_W-1:0] P_DST = 2'b10;

  typedef struct packed {
    logic [ENUM_W-1:0] sel;
    logic [PARM_W-1:0] parm;
  } cword_t;

  typedef struct packed {
    logic [CNT_W-1:0]          n_steps;
    logic [MAX_STEPS-1:0]      wait_irq;
    cword_t [MAX_STEPS-1:0]    word;
  } seq_t;
endpackage

// File: rtl/useq_decode.sv
module useq_decode
  import useq_pkg::*;
(
  input  logic [INSTR_W-1:0] instr_i,
  output seq_t               seq_o,
  output logic               is_jump_o,
  output logic [2:0]         cond_o
);
  always_comb begin
    seq_o     = '0;
    is_jump_o = 1'b0;
    cond_o    = instr_i[2:0];
    if (instr_i == '0) begin
      seq_o.n_steps = '0;
    end else if (instr_i[7:6] == 2'b00) begin
      seq_o.n_steps      = CNT_W'(2);
      seq_o.word[0].sel  = {2'b00, instr_i[5:3]};
      seq_o.word[0].parm = P_SRC;
      seq_o.word[1].sel  = {2'b00, instr_i[2:0]};
      seq_o.word[1].parm = P_DST;
    end else if (instr_i[7:1] == 7'b0101010) begin
      seq_o.n_steps      = CNT_W'(4);
      seq_o.word[0].sel  = E_FLAGS;
      seq_o.word[0].parm = P_SRC;
      seq_o.word[1].sel  = {4'b0001, ~instr_i[0]};
      seq_o.word[1].parm = P_SRC;
      seq_o.word[2].sel  = E_ADD;
      seq_o.word[2].parm = P_DST;
      seq_o.word[3].sel  = {4'b0001, instr_i[0]};
      seq_o.word[3].parm = P_DST;
    end else if (instr_i[7:2] == 6'b011010) begin
      seq_o.n_steps      = CNT_W'(2);
      seq_o.wait_irq[0]  = 1'b1;
      seq_o.word[0].sel  = E_SHIFT;
      seq_o.word[0].parm = instr_i[1:0];
      seq_o.word[1].sel  = E_AX;
      seq_o.word[1].parm = P_DST;
    end else if (instr_i[7:3] == 5'b11000) begin
      is_jump_o = 1'b1;
    end
  end
endmodule

// File: rtl/useq_cond.sv
module useq_cond
  import useq_pkg::*;
(
  input  logic [FLAG_W-1:0] flags_i,
  input  logic [2:0]        cond_i,
  output logic              take_o
);
  always_comb begin
    case (cond_i)
      3'd0:    take_o = flags_i[F_ZERO];
      3'd1:    take_o = flags_i[F_ZERO] | flags_i[F_EQUAL];
      3'd2:    take_o = flags_i[F_EQUAL];
      3'd3:    take_o = ~flags_i[F_EQUAL];
      3'd4:    take_o = flags_i[F_EQUAL] | flags_i[F_GREAT];
      3'd5:    take_o = flags_i[F_GREAT];
      3'd6:    take_o = flags_i[F_CARRY];
      default: take_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/useq_timer.sv
module useq_timer #(
  parameter int STEP_TICKS = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  input  logic hold_i,
  output logic step_end_o,
  output logic bus_clk_o
);
  localparam int TW = $clog2(STEP_TICKS + 1);
  localparam logic [TW-1:0] LAST = TW'(STEP_TICKS - 1);
  localparam logic [TW-1:0] EDGE = TW'(2);

  logic [TW-1:0] tick_q;
  logic          last;

  assign last       = (tick_q == LAST);
  assign step_end_o = active_i && last && !hold_i;
  assign bus_clk_o  = active_i && (tick_q >= EDGE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      tick_q <= '0;
    else if (!active_i || step_end_o) tick_q <= '0;
    else if (!last)                   tick_q <= tick_q + TW'(1);
  end
endmodule

// File: rtl/microstep_sequencer.sv
module microstep_sequencer
  import useq_pkg::*;
#(
  parameter int PC_W       = 8,
  parameter int STEP_TICKS = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [INSTR_W-1:0] instr_i,
  input  logic               instr_valid_i,
  input  logic [FLAG_W-1:0]  flags_i,
  input  logic [PC_W-1:0]    ip_i,
  input  logic               alu_irq_i,
  output logic               fetch_o,
  output logic               step_o,
  output logic [CTRL_W-1:0]  ctrl_o,
  output logic               bus_clk_o,
  output logic [PC_W-1:0]    pc_o
);
  typedef enum logic {S_IDLE, S_RUN} st_t;

  st_t              st_q;
  seq_t             seq_q;
  seq_t             dec_seq;
  logic [IDX_W-1:0] idx_q;
  logic [PC_W-1:0]  pc_q;
  logic             seen_q;
  logic             dec_jump, take;
  logic [2:0]       dec_cond;
  logic             run, accept, hold, step_end, last_step;
  cword_t           cur_word;

  useq_decode u_dec (
    .instr_i   (instr_i),
    .seq_o     (dec_seq),
    .is_jump_o (dec_jump),
    .cond_o    (dec_cond)
  );

  useq_cond u_cond (
    .flags_i (flags_i),
    .cond_i  (dec_cond),
    .take_o  (take)
  );

  assign run       = (st_q == S_RUN);
  assign accept    = (st_q == S_IDLE) && instr_valid_i;
  assign cur_word  = seq_q.word[idx_q];
  assign hold      = seq_q.wait_irq[idx_q] && !(seen_q || alu_irq_i);
  assign last_step = ({1'b0, idx_q} == (seq_q.n_steps - CNT_W'(1)));

  useq_timer #(.STEP_TICKS(STEP_TICKS)) u_tmr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .active_i   (run),
    .hold_i     (hold),
    .step_end_o (step_end),
    .bus_clk_o  (bus_clk_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      seq_q  <= '0;
      idx_q  <= '0;
      pc_q   <= '0;
      seen_q <= 1'b0;
    end else if (accept) begin
      seq_q  <= dec_seq;
      idx_q  <= '0;
      seen_q <= 1'b0;
      if (dec_seq.n_steps == '0) pc_q <= (dec_jump && take) ? ip_i : pc_q + PC_W'(1);
      else                       st_q <= S_RUN;
    end else if (run) begin
      if (step_end) begin
        seen_q <= 1'b0;
        if (last_step) begin
          st_q <= S_IDLE;
          pc_q <= pc_q + PC_W'(1);
        end else begin
          idx_q <= idx_q + IDX_W'(1);
        end
      end else if (alu_irq_i) begin
        seen_q <= 1'b1;
      end
    end
  end

  assign fetch_o = !run;
  assign step_o  = run;
  assign ctrl_o  = run ? cur_word : '0;
  assign pc_o    = pc_q;
endmodule

// File: rtl/useq_checker.sv
module useq_checker #(
  parameter int PC_W = 8
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [7:0]      instr_i,
  input logic            instr_valid_i,
  input logic [PC_W-1:0] ip_i,
  input logic            alu_irq_i,
  input logic            fetch_o,
  input logic            step_o,
  input logic [6:0]      ctrl_o,
  input logic            bus_clk_o,
  input logic [PC_W-1:0] pc_o
);
  logic in_shift, irq_seen_c;
  assign in_shift = step_o && (ctrl_o[6:2] == 5'b01101);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        irq_seen_c <= 1'b0;
    else if (!in_shift) irq_seen_c <= 1'b0;
    else if (alu_irq_i) irq_seen_c <= 1'b1;
  end

  p_idle_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_o |-> (ctrl_o == '0) && !bus_clk_o);

  p_bus_clk_late_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_clk_o) |-> $past(step_o, 2) && $stable(ctrl_o));

  p_step_start_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(step_o) |-> !bus_clk_o ##1 (step_o && !bus_clk_o));

  p_shift_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_shift && !(irq_seen_c || alu_irq_i) |=> step_o && (ctrl_o == $past(ctrl_o)));

  p_pc_after_steps_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(step_o) |-> pc_o == $past(pc_o) + PC_W'(1));

  p_pc_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_o && !instr_valid_i) |=> $stable(pc_o));

  p_jump_target_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_o && instr_valid_i && instr_i[7:3] == 5'b11000)
      |=> (pc_o == $past(ip_i)) || (pc_o == $past(pc_o) + PC_W'(1)));

  p_fetch_vs_step_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_o != step_o);
endmodule

bind microstep_sequencer useq_checker #(.PC_W(PC_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .instr_i       (instr_i),
  .instr_valid_i (instr_valid_i),
  .ip_i          (ip_i),
  .alu_irq_i     (alu_irq_i),
  .fetch_o       (fetch_o),
  .step_o        (step_o),
  .ctrl_o        (ctrl_o),
  .bus_clk_o     (bus_clk_o),
  .pc_o          (pc_o)
);

// File: tb/tb_microstep_sequencer.sv
`timescale 1ns/1ps
module tb_microstep_sequencer;
  localparam int PC_W = 8;
  localparam int ST   = 4;

  logic            clk = 1'b0;
  logic            rst_ni = 1'b0;
  logic [7:0]      instr = '0;
  logic            vld = 1'b0;
  logic [3:0]      flags = '0;
  logic [PC_W-1:0] ip = '0;
  logic            irq = 1'b0;
  logic            fetch_o, step_o, bus_clk_o;
  logic [6:0]      ctrl_o;
  logic [PC_W-1:0] pc_o;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  microstep_sequencer #(.PC_W(PC_W), .STEP_TICKS(ST)) dut (
    .clk_i (clk), .rst_ni (rst_ni), .instr_i (instr), .instr_valid_i (vld),
    .flags_i (flags), .ip_i (ip), .alu_irq_i (irq), .fetch_o (fetch_o),
    .step_o (step_o), .ctrl_o (ctrl_o), .bus_clk_o (bus_clk_o), .pc_o (pc_o)
  );

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, got, exp, $time);
    end
  endtask

  // reference model
  typedef struct { logic [6:0] w; bit wt; } ent_t;
  ent_t            mq[$];
  bit              m_busy = 0, m_seen = 0;
  int              m_tick = 0;
  logic [PC_W-1:0] m_pc = '0;

  function automatic bit ref_take(input int c, input logic [3:0] f);
    bit z = f[0], e = f[1], g = f[2], cy = f[3];
    case (c)
      0: return z;       1: return z || e;
      2: return e;       3: return !e;
      4: return e || g;  5: return g;
      6: return cy;      default: return 1;
    endcase
  endfunction

  function automatic void push(input logic [6:0] w, input bit wt);
    ent_t e; e.w = w; e.wt = wt; mq.push_back(e);
  endfunction

  function automatic void ref_decode(input logic [7:0] op, output bit jmp, output int c);
    jmp = 0; c = 0;
    if (op == 8'h00) return;
    if (op[7:6] == 2'b00) begin
      push({2'b00, op[5:3], 2'b01}, 0);
      push({2'b00, op[2:0], 2'b10}, 0);
    end else if (op[7:1] == 7'b0101010) begin
      push(7'b0000101, 0);
      push({4'b0001, ~op[0], 2'b01}, 0);
      push(7'b0101010, 0);
      push({4'b0001, op[0], 2'b10}, 0);
    end else if (op[7:2] == 6'b011010) begin
      push({5'b01101, op[1:0]}, 1);
      push(7'b0001010, 0);
    end else if (op[7:3] == 5'b11000) begin
      jmp = 1; c = int'(op[2:0]);
    end
  endfunction

  always @(negedge clk) begin
    chk("R5/R10 step_o", step_o, m_busy);
    chk("R2/R4/R6 ctrl_o", ctrl_o, m_busy ? mq[0].w : 7'h0);
    chk("R5 bus_clk_o", bus_clk_o, m_busy && m_tick >= 2);
    chk("R10 fetch_o", fetch_o, !m_busy);
    chk("R7/R9 pc_o", pc_o, m_pc);
    if (!rst_ni) begin
      m_busy = 0; m_seen = 0; m_tick = 0; m_pc = '0; mq.delete();
    end else if (!m_busy) begin
      if (vld) begin
        bit j; int c;
        ref_decode(instr, j, c);
        if (mq.size() == 0) m_pc = (j && ref_take(c, flags)) ? ip : m_pc + 1;
        else begin m_busy = 1; m_tick = 0; m_seen = 0; end
      end
    end else begin
      if (m_tick < ST - 1) begin
        m_tick++;
        if (irq) m_seen = 1;
      end else if (mq[0].wt && !(m_seen || irq)) begin
        // held waiting for the ALU
      end else begin
        void'(mq.pop_front());
        m_tick = 0; m_seen = 0;
        if (mq.size() == 0) begin m_busy = 0; m_pc = m_pc + 1; end
      end
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wait_idle();
    while (!fetch_o) tick();
  endtask

  task automatic issue(input logic [7:0] op, input logic [3:0] fl, input logic [PC_W-1:0] ipv,
                       input int irq_dly, input bit stray);
    wait_idle();
    instr = op; flags = fl; ip = ipv; vld = 1'b1;
    tick();
    vld = 1'b0;
    if (stray && step_o) begin
      instr = 8'h55; flags = 4'hF; ip = ~ipv; vld = 1'b1;
      tick();
      vld = 1'b0;
    end
    if (irq_dly >= 0) begin
      for (int k = 0; k < irq_dly; k++) tick();
      if (irq_dly >= ST) begin
        chk("R6 held step_o", step_o, 1);
        chk("R6 held ctrl_o", ctrl_o, {5'b01101, op[1:0]});
      end
      irq = 1'b1; tick(); irq = 1'b0;
    end
    wait_idle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R10 watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [PC_W-1:0] pc0;
    #1;
    repeat (3) tick();
    // R1 reset state
    chk("R1 pc_o", pc_o, 0);
    chk("R1 fetch_o", fetch_o, 1);
    chk("R1 step_o", step_o, 0);
    chk("R1 ctrl_o", ctrl_o, 0);
    rst_ni = 1'b1;
    tick();

    // R3 NOP and undecoded
    pc0 = pc_o; issue(8'h00, 4'h0, 8'h00, -1, 0);
    chk("R3 nop pc", pc_o, pc0 + 1);
    chk("R3 nop fetch", fetch_o, 1);
    pc0 = pc_o; issue(8'h80, 4'h0, 8'h00, -1, 0);
    chk("R3 undecoded pc", pc_o, pc0 + 1);
    pc0 = pc_o; issue(8'hF7, 4'hF, 8'h33, -1, 0);
    chk("R3 undecoded pc", pc_o, pc0 + 1);

    // R2 moves, R10 stray request mid-run
    pc0 = pc_o; issue(8'b00_010_011, 4'h0, 8'h00, -1, 1);
    chk("R7 mov pc", pc_o, pc0 + 1);
    pc0 = pc_o; issue(8'b00_101_110, 4'h0, 8'h00, -1, 0);
    chk("R2 mov pc", pc_o, pc0 + 1);

    // R4 increments
    wait_idle();
    instr = 8'h54; vld = 1'b1; tick(); vld = 1'b0;
    chk("R4 first word", ctrl_o, 7'b0000101);
    wait_idle();
    issue(8'h55, 4'h0, 8'h00, -1, 1);

    // R6 shifts with early and late ALU pulses
    issue(8'h69, 4'h0, 8'h00, 1, 0);
    issue(8'h6A, 4'h0, 8'h00, 9, 0);
    issue(8'h6B, 4'h0, 8'h00, 3, 0);
    issue(8'h68, 4'h0, 8'h00, 5, 0);

    // R8 R9 jumps over all conditions
    for (int c = 0; c < 8; c++) begin
      for (int f = 0; f < 16; f += 5) begin
        logic [PC_W-1:0] tgt;
        bit tk;
        tgt = PC_W'(8'h20 + c * 16 + f);
        tk  = ref_take(c, 4'(f));
        pc0 = pc_o;
        issue({5'b11000, 3'(c)}, 4'(f), tgt, -1, 0);
        chk("R8/R9 jump pc", pc_o, tk ? tgt : pc0 + 1);
      end
    end

    // back-to-back requests with valid held high
    wait_idle();
    instr = 8'b00_011_010; vld = 1'b1;
    repeat (20) tick();
    vld = 1'b0;
    wait_idle();
    repeat (3) tick();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule